// File: doc/BRIEF.md
# Interleaved Bus Slot Arbiter

This block shares a single memory bus between a processor and a video fetch unit by dividing time into fixed slots. A free-running two-bit phase counter steps once per processor clock. Phases 0 and 1 form the processor's slot and phases 2 and 3 form the video slot. The rotation never pauses: the video side gets its slot on every pass, even when it has nothing to fetch, such as during blanking.

A processor bus cycle may only begin at phase 0. As a result, any two processor accesses are separated by a multiple of four clocks. The processor raises a request and holds it until it is acknowledged. A request that arrives off phase 0 is held with wait states until the next phase 0. The block does not tell instruction fetches apart from operand accesses; both use the same request line.

When a DMA hold is active, or a slow device is selected, the acknowledge is pushed out by further whole slots. When a request was delayed only to reach alignment, the block pulses a flag and reports how many wait cycles were inserted.

Top module: `slot_arbiter`

## Requirements
- R1: After a synchronous active-high reset, `slot_phase` is 0. It then advances by one each clock, modulo 4.
- R2: `vid_owner` is high in phases 2 and 3 and low in phases 0 and 1.
- R3: `vid_grant` is high exactly in phase 2 of every rotation. `cpu_req` and `dma_hold` have no effect on it.
- R4: `cpu_ack` is only ever high in phase 0. A request held high continuously is acknowledged once per rotation.
- R5: A request raised in phase 0, with no hold and no slow select, is acknowledged in that same cycle, and `misalign` stays low.
- R6: A request raised in phase p (p = 1, 2 or 3), with no hold and no slow select, is acknowledged (4 - p) cycles later. A request raised in phase 2 is therefore delayed by exactly 2 cycles.
- R7: `misalign` is high for one cycle, together with `cpu_ack`, only when a request was delayed for alignment alone. In that cycle `misalign_waits` equals (4 - p) mod 4, where p is the phase in which the request was raised.
- R8: While `dma_hold` is high in phase 0, no acknowledge is given and the request stays pending. It is acknowledged at the first phase 0 without the hold, and `misalign` stays low.
- R9: With `cpu_slow` held high alongside the request, the acknowledge comes SLOW_SLOTS whole rotations after the first aligned phase 0 (default 2), and `misalign` stays low.
- R10: Reset discards a pending request. A request still held when reset is released counts as new, and is therefore acknowledged in the first cycle after reset with `misalign` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor bus request, held until acknowledged |
| cpu_slow | input | 1 | Addressed device is slow; held with the request |
| dma_hold | input | 1 | DMA is holding the bus |
| cpu_ack | output | 1 | Processor bus cycle starts this clock |
| misalign | output | 1 | Request was delayed for alignment only |
| misalign_waits | output | 2 | Wait cycles inserted for alignment |
| vid_grant | output | 1 | Video fetch strobe, phase 2 |
| vid_owner | output | 1 | Video side owns the bus this clock |
| slot_phase | output | 2 | Current slot phase |

## Verification
On every cycle, the assertions check the following: the phase steps by one; the video grant falls inside video ownership and never repeats on consecutive cycles; an acknowledge never coincides with video ownership or a DMA hold; and a misalignment report always comes with an acknowledge, carrying a wait count equal to the cycles actually spent waiting. The bench scenarios are needed to show the exact acknowledge latency for each start phase and each mix of DMA hold and slow select. They also show that a continuously held request is served once per rotation, and that reset discards a pending request.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int PHASE_W = 2;
  localparam int PHASES  = 1 << PHASE_W;

  typedef logic [PHASE_W-1:0] phase_t;

  localparam phase_t PH_CPU_A = phase_t'(0);
  localparam phase_t PH_CPU_B = phase_t'(1);
  localparam phase_t PH_VID_A = phase_t'(2);
  localparam phase_t PH_VID_B = phase_t'(3);

  // Cycles from phase p to the next CPU slot start (0 when already there).
  function automatic phase_t align_waits(input phase_t p);
    logic [PHASE_W:0] full;
    full = (PHASE_W+1)'(PHASES) - {1'b0, p};
    return full[PHASE_W-1:0];
  endfunction

  function automatic logic is_video_phase(input phase_t p);
    return p[PHASE_W-1];
  endfunction
endpackage

// File: rtl/slot_phase_gen.sv
module slot_phase_gen
  import slot_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase,
  output logic   cpu_slot_open
);
  phase_t phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_CPU_A;
    else     phase_q <= phase_q + phase_t'(1);
  end

  assign phase         = phase_q;
  assign cpu_slot_open = (phase_q == PH_CPU_A);

  p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase == $past(phase) + phase_t'(1));
endmodule

// File: rtl/video_slot_gen.sv
module video_slot_gen
  import slot_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase,
  output logic   vid_grant,
  output logic   vid_owner
);
  assign vid_owner = is_video_phase(phase);
  assign vid_grant = (phase == PH_VID_A);

  p_grant_owned_r2: assert property (@(posedge clk) disable iff (rst)
    vid_grant |-> vid_owner);
  p_grant_single_r3: assert property (@(posedge clk) disable iff (rst)
    vid_grant |=> !vid_grant && vid_owner);
endmodule

// File: rtl/cpu_slot_ctrl.sv
module cpu_slot_ctrl
  import slot_arb_pkg::*;
#(
  parameter int SLOW_SLOTS = 2,
  parameter int WAIT_W     = 6
) (
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase,
  input  logic   slot_open,
  input  logic   cpu_req,
  input  logic   cpu_slow,
  input  logic   dma_hold,
  output logic   cpu_ack,
  output logic   misalign,
  output phase_t misalign_waits
);
  localparam int EXT_W = (SLOW_SLOTS < 1) ? 1 : $clog2(SLOW_SLOTS + 1);
  localparam logic [EXT_W-1:0] EXT_LOAD =
    (SLOW_SLOTS < 1) ? '0 : EXT_W'(SLOW_SLOTS - 1);

  logic              tracking;
  phase_t            start_ph;
  logic [WAIT_W-1:0] elapsed;
  logic              blocked;
  logic              ext_armed;
  logic [EXT_W-1:0]  ext_left;
  logic              ext_ok;
  logic              waiting;

  assign ext_ok  = !cpu_slow || (SLOW_SLOTS == 0) || (ext_armed && ext_left == '0);
  assign cpu_ack = cpu_req && !rst && slot_open && !dma_hold && ext_ok;
  assign waiting = cpu_req && !cpu_ack;

  assign misalign       = cpu_ack && tracking && !blocked;
  assign misalign_waits = misalign ? align_waits(start_ph) : phase_t'(0);

  always_ff @(posedge clk) begin
    if (rst || !waiting) begin
      tracking  <= 1'b0;
      start_ph  <= PH_CPU_A;
      elapsed   <= '0;
      blocked   <= 1'b0;
      ext_armed <= 1'b0;
      ext_left  <= '0;
    end else begin
      tracking <= 1'b1;
      if (!tracking) begin
        start_ph <= phase;
        elapsed  <= WAIT_W'(1);
      end else if (elapsed != '1) begin
        elapsed <= elapsed + WAIT_W'(1);
      end
      if (slot_open) begin
        blocked <= 1'b1;
        if (cpu_slow && !ext_armed) begin
          ext_armed <= 1'b1;
          ext_left  <= EXT_LOAD;
        end else if (ext_armed && ext_left != '0) begin
          ext_left <= ext_left - EXT_W'(1);
        end
      end
    end
  end

  p_dma_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    dma_hold |-> !cpu_ack);
  p_misalign_with_ack_r7: assert property (@(posedge clk) disable iff (rst)
    misalign |-> cpu_ack && misalign_waits != phase_t'(0));
  p_misalign_waits_r7: assert property (@(posedge clk) disable iff (rst)
    misalign |-> elapsed == WAIT_W'(misalign_waits));
  p_ack_single_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int SLOW_SLOTS = 2,
  parameter int WAIT_W     = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_req,
  input  logic       cpu_slow,
  input  logic       dma_hold,
  output logic       cpu_ack,
  output logic       misalign,
  output logic [1:0] misalign_waits,
  output logic       vid_grant,
  output logic       vid_owner,
  output logic [1:0] slot_phase
);
  phase_t phase;
  logic   slot_open;
  phase_t waits;

  slot_phase_gen u_phase (
    .clk           (clk),
    .rst           (rst),
    .phase         (phase),
    .cpu_slot_open (slot_open)
  );

  video_slot_gen u_video (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .vid_grant (vid_grant),
    .vid_owner (vid_owner)
  );

  cpu_slot_ctrl #(.SLOW_SLOTS(SLOW_SLOTS), .WAIT_W(WAIT_W)) u_cpu (
    .clk            (clk),
    .rst            (rst),
    .phase          (phase),
    .slot_open      (slot_open),
    .cpu_req        (cpu_req),
    .cpu_slow       (cpu_slow),
    .dma_hold       (dma_hold),
    .cpu_ack        (cpu_ack),
    .misalign       (misalign),
    .misalign_waits (waits)
  );

  assign slot_phase     = phase;
  assign misalign_waits = waits;

  p_ack_cpu_slot_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |-> !vid_owner && !vid_grant);
  p_ack_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack && !vid_owner);
endmodule

// File: tb/sim_slot_arbiter.sv
module sim_slot_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_slow = 1'b0, dma_hold = 1'b0;
  logic cpu_ack, misalign, vid_grant, vid_owner;
  logic [1:0] misalign_waits, slot_phase;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slot_arbiter u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_slow(cpu_slow),
    .dma_hold(dma_hold), .cpu_ack(cpu_ack), .misalign(misalign),
    .misalign_waits(misalign_waits), .vid_grant(vid_grant),
    .vid_owner(vid_owner), .slot_phase(slot_phase)
  );

  // {start phase[2], slow, dma rotations[2], latency[5], misalign, waits[2]}
  localparam logic [12:0] VEC [10] = '{
    {2'd0, 1'b0, 2'd0, 5'd0,  1'b0, 2'd0},
    {2'd1, 1'b0, 2'd0, 5'd3,  1'b1, 2'd3},
    {2'd2, 1'b0, 2'd0, 5'd2,  1'b1, 2'd2},
    {2'd3, 1'b0, 2'd0, 5'd1,  1'b1, 2'd1},
    {2'd2, 1'b1, 2'd0, 5'd10, 1'b0, 2'd0},
    {2'd1, 1'b0, 2'd1, 5'd7,  1'b0, 2'd0},
    {2'd3, 1'b1, 2'd3, 5'd13, 1'b0, 2'd0},
    {2'd0, 1'b0, 2'd2, 5'd8,  1'b0, 2'd0},
    {2'd2, 1'b1, 2'd1, 5'd10, 1'b0, 2'd0},
    {2'd1, 1'b1, 2'd0, 5'd11, 1'b0, 2'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_phase(input int p);
    @(negedge clk);
    while (slot_phase != 2'(p)) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int acks, grants, lat, zeros, dmax;
    logic [12:0] v;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1/R2/R3/R4 reset state
    check("R1 reset phase", slot_phase, 0);
    check("R4 reset ack", cpu_ack, 0);
    check("R3 reset grant", vid_grant, 0);
    rst = 1'b0;
    // R1/R2: phase sequence and ownership
    for (int i = 0; i < 8; i++) begin
      check("R1 phase step", slot_phase, i % 4);
      check("R2 owner", vid_owner, ((i % 4) >= 2) ? 1 : 0);
      @(negedge clk);
    end
    // Table walk: R5 R6 R7 R8 R9
    for (int k = 0; k < 10; k++) begin
      v = VEC[k];
      wait_phase(v[12:11]);
      cpu_req = 1'b1; cpu_slow = v[10];
      dmax = v[9:8]; zeros = 0; lat = 0;
      dma_hold = (slot_phase == 2'd0) && (zeros < dmax);
      if (slot_phase == 2'd0) zeros++;
      #1;
      while (!cpu_ack && lat < 40) begin
        @(negedge clk);
        lat++;
        dma_hold = (slot_phase == 2'd0) && (zeros < dmax);
        if (slot_phase == 2'd0) zeros++;
        #1;
      end
      check("R6 R8 R9 ack latency", lat, v[7:3]);
      check("R5 R7 misalign", misalign, v[2]);
      check("R7 misalign_waits", misalign_waits, v[1:0]);
      @(negedge clk);
      cpu_req = 1'b0; cpu_slow = 1'b0; dma_hold = 1'b0;
    end
    // R3: grant unaffected by request and hold
    wait_phase(0);
    cpu_req = 1'b1; dma_hold = 1'b1; grants = 0;
    for (int i = 0; i < 8; i++) begin
      #1;
      if (vid_grant) begin
        grants++;
        check("R3 grant phase", slot_phase, 2);
      end
      check("R8 no ack under hold", cpu_ack, 0);
      @(negedge clk);
    end
    check("R3 grant count", grants, 2);
    // R4: continuous request served once per rotation, only in phase 0
    dma_hold = 1'b0; acks = 0;
    for (int i = 0; i < 12; i++) begin
      #1;
      if (cpu_ack) begin
        acks++;
        check("R4 ack phase", slot_phase, 0);
      end
      @(negedge clk);
    end
    check("R4 ack count", acks, 3);
    cpu_req = 1'b0;
    // R10: reset discards a pending request
    wait_phase(1);
    cpu_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R10 phase after reset", slot_phase, 0);
    check("R10 ack after reset", cpu_ack, 1);
    check("R10 misalign after reset", misalign, 0);
    @(negedge clk);
    cpu_req = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule